// File: doc/BRIEF.md
# Weight-Stationary Convolution Row Array

This block computes one output row of a two-dimensional convolution with a chain of multiply-accumulate elements. There are TAPS elements, one per filter column. Each element keeps a single filter weight in its own register. Every activation of the input row is presented to all elements in the same cycle. The running partial sum moves one element along the chain on each step, so each element contributes to a neighbouring output position. The row is extended with zero padding of (TAPS-1)/2 positions on each side, so the output row is as wide as the input row.

A partial sum from an earlier filter row can be added to each output position. It is presented together with the activation of the same position. A bypass flag marks the first filter row, where that incoming value is taken as zero. The sum that leaves the block either feeds the next filter row or is the final result. Weights are shifted in serially before a row starts. They then stay in place for any number of rows.

With PAD = (TAPS-1)/2, the output for position k is the saturated value of p[k] + sum over j of w[j]*x[k+j-PAD]. An activation whose index falls outside the row counts as zero. TAPS must be odd.

Top module: `ws_conv_row`

## Requirements
- R1: While `wt_load` is high, each cycle shifts `wt_in` into the weight chain. After TAPS such cycles, the value loaded first sits in tap 0, which meets the leftmost activation x[k-PAD]. While `wt_load` is low, `wt_in` has no effect on the weights.
- R2: For a row of ROW_W activations, the block produces ROW_W outputs. Output k is p[k] + sum over j of w[j]*x[k+j-PAD], where x is zero outside indices 0..ROW_W-1 and p[k] is the `psum_in` value presented with activation k.
- R3: Every sum saturates to the signed 24-bit range and does not wrap. The upper limit is 8388607 and the lower limit is -8388608.
- R4: When `psum_bypass` is high together with activation k, p[k] is taken as zero, whatever value `psum_in` has.
- R5: If the first activation of a row is sampled in cycle c, `out_valid` is first high in cycle c+PAD+2, which is cycle c+3 for the default of three taps. It then stays high for exactly ROW_W consecutive cycles, and carries output k in the k-th of those cycles.
- R6: During reset and in every cycle where `out_valid` is low, `out_valid` reads 0 and `out_psum` reads 0.
- R7: A new row may start once at least PAD cycles without a valid activation have followed the previous row. No partial sum of the previous row appears in the new row's outputs.
- R8: Loaded weights stay in use for every following row until the next load. No reload is needed between rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wt_load | input | 1 | Shifts `wt_in` into the weight chain this cycle |
| wt_in | input | 8 | Signed weight value for the serial load |
| act_valid | input | 1 | Qualifies `act_in`, `psum_in` and `psum_bypass` |
| act_in | input | 8 | Signed activation, presented to every tap at once |
| psum_in | input | 24 | Signed partial sum from the previous filter row, for the same position as `act_in` |
| psum_bypass | input | 1 | Treats `psum_in` as zero (first filter row) |
| out_valid | output | 1 | Marks an output position on `out_psum` |
| out_psum | output | 24 | Signed saturated partial sum for the next row, or the final sum |

## Verification
The assertions assume the following about the inputs:
- Every row arrives as exactly ROW_W activations on consecutive cycles.
- At least PAD idle cycles separate one row from the next.
- `wt_load` is never raised while an activation is valid.

These assumptions are what let the output timing follow the activation stream with a fixed delay. The bench drives every row through one task, which emits the ROW_W activations back to back and then inserts an idle gap of at least PAD cycles. The bench loads weights only between rows. The tightest case, a gap of exactly PAD cycles, is driven on purpose.

// File: rtl/ws_row_pkg.sv
// Shared widths, types and saturating arithmetic for the convolution row array.
// Assumes two's-complement signed activations, weights and partial sums.
package ws_row_pkg;
    localparam int ACT_W  = 8;
    localparam int PSUM_W = 24;
    localparam int PROD_W = 2 * ACT_W;

    typedef logic signed [ACT_W-1:0]  act_t;
    typedef logic signed [PSUM_W-1:0] psum_t;

    localparam psum_t PSUM_MAX = {1'b0, {(PSUM_W-1){1'b1}}};
    localparam psum_t PSUM_MIN = {1'b1, {(PSUM_W-1){1'b0}}};

    // Adds two partial sums and clamps the result to the signed range.
    function automatic psum_t sat_add(psum_t a, psum_t b);
        logic [PSUM_W:0] s;
        s = {a[PSUM_W-1], a} + {b[PSUM_W-1], b};
        if (s[PSUM_W] != s[PSUM_W-1])
            return s[PSUM_W] ? PSUM_MIN : PSUM_MAX;
        return psum_t'(s[PSUM_W-1:0]);
    endfunction

    // Full-precision weight-by-activation product, sign-extended to partial-sum width.
    function automatic psum_t widen_prod(act_t w, act_t x);
        logic signed [PROD_W-1:0] p;
        p = w * x;
        return psum_t'(p);
    endfunction
endpackage

// File: rtl/ws_pe.sv
// One processing element of the chain.
// It holds one filter weight, which is part of a serial shift chain while loading.
// Each cycle it adds weight*activation to the partial sum from its neighbour.
// Assumes the weight does not change while a row is streaming.
module ws_pe
    import ws_row_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wt_load,
    input  act_t  wt_shift_in,
    output act_t  wt_q,
    input  act_t  act,
    input  psum_t chain_in,
    output psum_t chain_q
);
    // Stationary weight register, written only while loading.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wt_q <= '0;
        else if (wt_load)
            wt_q <= wt_shift_in;
    end

    // Accumulate this tap's product onto the neighbour's partial sum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= sat_add(chain_in, widen_prod(wt_q, act));
    end
endmodule

// File: rtl/ws_align.sv
// Fixed-depth register pipeline.
// It carries the valid flag and the incoming partial sum, so that they meet the chain output.
// Assumes DEPTH >= 1. It runs every cycle.
module ws_align #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [DEPTH];

    // First stage captures the input word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage[0] <= '0;
        else
            stage[0] <= d;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        // Each later stage copies its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage[i] <= '0;
            else
                stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/ws_row_seq.sv
// Row position counter.
// It flags the first activation of each row, which clears the chain links.
// Assumes every row is exactly ROW_W valid activations long.
module ws_row_seq #(
    parameter int ROW_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_valid,
    output logic row_start
);
    localparam int CW = (ROW_W > 1) ? $clog2(ROW_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(ROW_W - 1);

    logic [CW-1:0] pos;

    // Count valid activations and wrap at the end of a row.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (act_valid)
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end

    assign row_start = act_valid && (pos == '0);
endmodule

// File: rtl/ws_conv_row.sv
// Weight-stationary convolution row array (top).
// TAPS elements each hold one weight. The activation is broadcast to all of them.
// Partial sums ripple from tap 0 toward tap TAPS-1.
// Idle cycles feed zeros, and these supply the trailing padding.
// The leading padding is implied by clearing the links at row start.
// The incoming partial sum is delayed to meet the chain output and added in a final saturating stage.
// Assumes odd TAPS, contiguous rows of ROW_W, and at least PAD idle cycles between rows.
module ws_conv_row
    import ws_row_pkg::*;
#(
    parameter int TAPS  = 3,
    parameter int ROW_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wt_load,
    input  logic signed [ACT_W-1:0]  wt_in,
    input  logic                     act_valid,
    input  logic signed [ACT_W-1:0]  act_in,
    input  logic signed [PSUM_W-1:0] psum_in,
    input  logic                     psum_bypass,
    output logic                     out_valid,
    output logic signed [PSUM_W-1:0] out_psum
);
    localparam int PAD   = (TAPS - 1) / 2;
    localparam int ALIGN = PAD + 1;

    act_t  x_bcast;
    logic  row_start;
    act_t  wt_q    [TAPS];
    psum_t chain_q [TAPS];
    psum_t link    [TAPS];
    psum_t psum_eff;
    logic  [PSUM_W:0] al_d;
    logic  [PSUM_W:0] al_q;
    logic  al_valid;
    psum_t al_psum;

    // Broadcast activation; idle cycles contribute zero (trailing pad).
    assign x_bcast  = act_valid ? act_in : '0;
    assign psum_eff = psum_bypass ? '0 : psum_in;
    assign al_d     = {act_valid, psum_eff};
    assign al_valid = al_q[PSUM_W];
    assign al_psum  = al_q[PSUM_W-1:0];

    ws_row_seq #(.ROW_W(ROW_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (act_valid),
        .row_start (row_start)
    );

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        act_t shift_src;
        if (i == 0) begin : g_head
            assign link[i] = '0;
        end else begin : g_body
            assign link[i] = row_start ? '0 : chain_q[i-1];
        end
        if (i == TAPS - 1) begin : g_wlast
            assign shift_src = wt_in;
        end else begin : g_wmid
            assign shift_src = wt_q[i+1];
        end
        ws_pe u_pe (
            .clk         (clk),
            .rst_n       (rst_n),
            .wt_load     (wt_load),
            .wt_shift_in (shift_src),
            .wt_q        (wt_q[i]),
            .act         (x_bcast),
            .chain_in    (link[i]),
            .chain_q     (chain_q[i])
        );
    end

    ws_align #(.DEPTH(ALIGN), .WIDTH(PSUM_W + 1)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (al_d),
        .q     (al_q)
    );

    // Final stage: add the aligned previous-row partial sum to the chain output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_psum  <= '0;
        end else begin
            out_valid <= al_valid;
            out_psum  <= al_valid ? sat_add(chain_q[TAPS-1], al_psum) : '0;
        end
    end
endmodule

// File: rtl/ws_conv_row_chk.sv
// Assertion checker for ws_conv_row, attached with bind.
// It checks the input rules the design relies on, the output timing and the idle output value.
module ws_conv_row_chk
    import ws_row_pkg::*;
#(
    parameter int TAPS  = 3,
    parameter int ROW_W = 8
) (
    input logic  clk,
    input logic  rst_n,
    input logic  wt_load,
    input logic  act_valid,
    input logic  out_valid,
    input psum_t out_psum
);
    localparam int PAD = (TAPS - 1) / 2;
    localparam int RW  = $clog2(ROW_W + 1) + 1;
    localparam int GW  = $clog2(PAD + 1) + 1;
    localparam logic [RW-1:0] ROW_LEN = RW'(ROW_W);
    localparam logic [GW-1:0] GAP_MIN = GW'(PAD);

    logic [PAD+1:0] vpipe;
    logic [RW-1:0]  run_cnt;
    logic [GW-1:0]  gap_cnt;

    // History of act_valid, for the output timing check.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vpipe <= '0;
        else
            vpipe <= {vpipe[PAD:0], act_valid};
    end

    // Length of the current run of valid activations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (!act_valid)
            run_cnt <= '0;
        else if (run_cnt != '1)
            run_cnt <= run_cnt + 1'b1;
    end

    // Idle cycles since the last valid activation, saturating at PAD.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= GAP_MIN;
        else if (act_valid)
            gap_cnt <= '0;
        else if (gap_cnt < GAP_MIN)
            gap_cnt <= gap_cnt + 1'b1;
    end

    assert_load_outside_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> !wt_load);

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[PAD+1]);

    assert_row_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_valid) |-> run_cnt == ROW_LEN);

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_psum == '0);

    assert_row_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_valid) |-> gap_cnt >= GAP_MIN);
endmodule

bind ws_conv_row ws_conv_row_chk #(.TAPS(TAPS), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_load   (wt_load),
    .act_valid (act_valid),
    .out_valid (out_valid),
    .out_psum  (out_psum)
);

// File: tb/sim_ws_conv_row.sv
`timescale 1ns/1ps
// Self-checking bench for ws_conv_row.
// A behavioural model computes each row's outputs and the cycle each must appear in.
// The monitor compares the outputs on every clock.
module sim_ws_conv_row;
    import ws_row_pkg::*;

    localparam int TAPS  = 3;
    localparam int ROW_W = 8;
    localparam int PAD   = (TAPS - 1) / 2;
    localparam int LAT   = PAD + 2;

    logic        clk;
    logic        rst_n;
    logic        wt_load;
    act_t        wt_in;
    logic        act_valid;
    act_t        act_in;
    psum_t       psum_in;
    logic        psum_bypass;
    logic        out_valid;
    psum_t       out_psum;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 0;
    bit done = 0;

    int w_m [TAPS];
    int xr  [ROW_W];
    int pr  [ROW_W];
    bit br  [ROW_W];

    int    q_cyc [$];
    int    q_val [$];
    string q_tag [$];

    ws_conv_row #(.TAPS(TAPS), .ROW_W(ROW_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wt_load     (wt_load),
        .wt_in       (wt_in),
        .act_valid   (act_valid),
        .act_in      (act_in),
        .psum_in     (psum_in),
        .psum_bypass (psum_bypass),
        .out_valid   (out_valid),
        .out_psum    (out_psum)
    );

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sat24(longint v);
        if (v > 64'sd8388607)  return 8388607;
        if (v < -64'sd8388608) return -8388608;
        return int'(v);
    endfunction

    task automatic check(bit ok, string tag, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Per-cycle comparison against the model queue.
    always @(negedge clk) begin
        if (mon_on) begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                check(out_valid === 1'b1, q_tag[0], "out_valid", int'(out_valid), 1);
                check(int'(out_psum) == q_val[0], q_tag[0], "out_psum", int'(out_psum), q_val[0]);
                void'(q_cyc.pop_front());
                void'(q_val.pop_front());
                void'(q_tag.pop_front());
            end else begin
                check(out_valid === 1'b0, "R6", "idle out_valid", int'(out_valid), 0);
                check(out_psum == '0, "R6", "idle out_psum", int'(out_psum), 0);
            end
        end
    end

    task automatic load_weights();
        for (int j = 0; j < TAPS; j++) begin
            tick();
            wt_load = 1'b1;
            wt_in   = act_t'(w_m[j]);
        end
        tick();
        wt_load = 1'b0;
        wt_in   = '0;
    endtask

    task automatic send_row(string tag, int gap);
        int yk [ROW_W];
        for (int k = 0; k < ROW_W; k++) begin
            longint acc = br[k] ? 0 : longint'(pr[k]);
            for (int j = 0; j < TAPS; j++) begin
                int idx = k + j - PAD;
                if (idx >= 0 && idx < ROW_W) acc += longint'(w_m[j]) * longint'(xr[idx]);
            end
            yk[k] = sat24(acc);
        end
        for (int k = 0; k < ROW_W; k++) begin
            tick();
            act_valid   = 1'b1;
            act_in      = act_t'(xr[k]);
            psum_in     = psum_t'(pr[k]);
            psum_bypass = br[k];
            q_cyc.push_back(cyc + LAT);
            q_val.push_back(yk[k]);
            q_tag.push_back(tag);
        end
        tick();
        act_valid   = 1'b0;
        act_in      = '0;
        psum_in     = '0;
        psum_bypass = 1'b0;
        repeat (gap - 1) tick();
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: got %0d expected %0d pending outputs", q_cyc.size(), 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wt_load = 0; wt_in = '0; act_valid = 0; act_in = '0;
        psum_in = '0; psum_bypass = 0;
        repeat (3) tick();
        // R6: reset state
        check(out_valid === 1'b0, "R6", "reset out_valid", int'(out_valid), 0);
        check(out_psum == '0, "R6", "reset out_psum", int'(out_psum), 0);
        tick();
        rst_n = 1;
        mon_on = 1;
        tick();

        // R1: shift order (first value reaches tap 0), and wt_in ignored with load low
        w_m[0] = 1; w_m[1] = 0; w_m[2] = 0;
        load_weights();
        for (int n = 0; n < 5; n++) begin
            tick();
            wt_in = act_t'(37 * n - 60);
        end
        tick();
        wt_in = '0;
        for (int k = 0; k < ROW_W; k++) begin xr[k] = 10 * (k + 1); pr[k] = 999; br[k] = 1; end
        send_row("R1", 4);

        // R2: general filter with signed data, edges use zero padding
        w_m[0] = 1; w_m[1] = -2; w_m[2] = 3;
        load_weights();
        xr[0] = 5; xr[1] = -7; xr[2] = 12; xr[3] = 0;
        xr[4] = -128; xr[5] = 127; xr[6] = 3; xr[7] = -1;
        for (int k = 0; k < ROW_W; k++) begin pr[k] = 100 * k - 300; br[k] = 0; end
        send_row("R2", 4);

        // R4: bypass discards psum_in on alternate positions
        for (int k = 0; k < ROW_W; k++) begin
            xr[k] = 3 * k - 9; pr[k] = 123456 - k; br[k] = (k % 2) == 1;
        end
        send_row("R4", 3);

        // R5: output window timing with another pattern
        for (int k = 0; k < ROW_W; k++) begin
            xr[k] = (k * 29) % 61 - 30; pr[k] = -5000 + 17 * k; br[k] = 0;
        end
        send_row("R5", 5);

        // R3: positive and negative saturation
        w_m[0] = 127; w_m[1] = 127; w_m[2] = 127;
        load_weights();
        for (int k = 0; k < ROW_W; k++) begin xr[k] = 127; pr[k] = 8388000; br[k] = 0; end
        send_row("R3", 3);
        for (int k = 0; k < ROW_W; k++) begin xr[k] = -128; pr[k] = -8388000; br[k] = 0; end
        send_row("R3", 3);

        // R8 then R7: same weights over two rows, the second after the minimum gap
        w_m[0] = 2; w_m[1] = -1; w_m[2] = 4;
        load_weights();
        for (int k = 0; k < ROW_W; k++) begin xr[k] = 50 - 13 * k; pr[k] = 7 * k; br[k] = 0; end
        send_row("R8", PAD);
        for (int k = 0; k < ROW_W; k++) begin xr[k] = 11 * k - 40; pr[k] = 0; br[k] = 1; end
        send_row("R7", 3);

        repeat (LAT + 6) tick();
        check(q_cyc.size() == 0, "R5", "pending outputs", q_cyc.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule